// File: doc/BRIEF.md
# Programmable Frequency Lock Detector

The block counts two edge streams over one measurement window: a reference stream and a feedback stream, each given as single-cycle pulses that are already synchronized to the system clock. A window always spans `WIN_EDGES` reference edges. At the close of each window a state machine turns the feedback count into a fractional frequency error. It compares that error with a threshold chosen by a 3-bit code and publishes three things: a lock flag, a 10-bit error magnitude, and a unit flag that tells whether the magnitude is in parts per billion or parts per million.

The error is found with one sequential restoring divider that is used twice. The first pass gives the error in ppb. If the result does not fit in 10 bits, a second pass divides it by 1000 to give ppm, which saturates at 1023. The published values change only when a window closes, so the lock flag cannot chatter inside a window.

The controller has five states. `ST_IDLE` waits for a window to close and then moves to `ST_PPB_DIV`, which starts the ppb division. When that division is done the controller moves to `ST_PPB_EVAL`. From there it moves to `ST_PUBLISH` if the ppb value fits in 10 bits, or to `ST_PPM_DIV` if it does not. `ST_PPM_DIV` moves to `ST_PUBLISH` when the second division is done. `ST_PUBLISH` always returns to `ST_IDLE`.

Top module: `freq_lock_detect`

## Requirements
- R1: While `rst_n` is low, and after it, until the first result, `locked`=0, `err_mag`=0, `err_unit_ppm`=0 and `result_stb`=0. A reset in the middle of operation returns the outputs to these values.
- R2: A window closes on the cycle that carries its `WIN_EDGES`-th reference edge, and a feedback edge in that same cycle is counted in the window. The next window starts on the following cycle. `result_stb` pulses for exactly one cycle, once per window.
- R3: The feedback count F saturates at 2·`WIN_EDGES`. The error in ppb is floor(|F − `WIN_EDGES`| · 10^9 / `WIN_EDGES`).
- R4: If the ppb error is at most 1023, then `err_unit_ppm`=0 and `err_mag` holds the ppb value.
- R5: If the ppb error is above 1023, then `err_unit_ppm`=1 and `err_mag` = min(floor(ppb / 1000), 1023). This value is always at least 1.
- R6: Threshold codes 0 to 7 select 20 ppb, 100 ppb, 1 ppm, 5 ppm, 20 ppm, 50 ppm, 100 ppm and 300 ppm. The code is sampled on the cycle in which the window closes.
- R7: `locked` becomes 1 when the ppb error is strictly below the selected threshold, and 0 when the error is equal to the threshold or above it.
- R8: `locked`, `err_mag` and `err_unit_ppm` change only in the cycle in which `result_stb` is 1. They hold their values at all other times.
- R9: A feedback surplus and a feedback deficit of the same size give the same magnitude, unit and lock result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_edge | input | 1 | One-cycle pulse for each reference edge |
| fb_edge | input | 1 | One-cycle pulse for each feedback edge |
| thr_code | input | 3 | Lock threshold select |
| locked | output | 1 | Lock flag: 1 when the error is below the threshold |
| err_mag | output | 10 | Error magnitude |
| err_unit_ppm | output | 1 | Unit of `err_mag`: 1 = ppm, 0 = ppb |
| result_stb | output | 1 | One-cycle pulse when new results are published |

## Verification
The assertions assume that a window is never shorter than the two divider passes plus the publish cycle. In other words, a window close only ever arrives while the controller is in `ST_IDLE`. This holds because each reference edge takes at least one cycle and `WIN_EDGES` is far larger than twice the divider width. The stimulus respects this by sending one reference edge every second cycle. It places the extra feedback edges on the cycles between reference edges, so F can range from 0 to 2·`WIN_EDGES` without two edges of one stream ever arriving in the same cycle. The threshold code is held for a whole window and changes only after the window closes, which also tests that the code is captured at the window close.

// File: rtl/flock_pkg.sv
package flock_pkg;

    localparam int unsigned MAG_W      = 10;
    localparam int unsigned MAG_MAX    = 1023;
    localparam int unsigned PPB_SCALE  = 1000000000;
    localparam int unsigned PPB_PER_PPM = 1000;
    localparam int unsigned SCALE_W    = 30;
    localparam int unsigned THR_W      = 19;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PPB_DIV,
        ST_PPB_EVAL,
        ST_PPM_DIV,
        ST_PUBLISH
    } flock_state_t;

    // lock threshold in ppb for each select code
    function automatic logic [THR_W-1:0] thr_ppb(input logic [2:0] code);
        logic [THR_W-1:0] t;
        unique case (code)
            3'd0: t = THR_W'(20);
            3'd1: t = THR_W'(100);
            3'd2: t = THR_W'(1000);
            3'd3: t = THR_W'(5000);
            3'd4: t = THR_W'(20000);
            3'd5: t = THR_W'(50000);
            3'd6: t = THR_W'(100000);
            default: t = THR_W'(300000);
        endcase
        return t;
    endfunction

endpackage

// File: rtl/flock_window_counter.sv
module flock_window_counter #(
    parameter int unsigned WIN_EDGES = 1000000,
    localparam int unsigned RW = $clog2(WIN_EDGES + 1),
    localparam int unsigned FW = $clog2(2 * WIN_EDGES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ref_edge,
    input  logic          fb_edge,
    output logic          win_end,
    output logic [FW-1:0] fb_total
);

    localparam logic [RW-1:0] REF_LAST = RW'(WIN_EDGES - 1);
    localparam logic [FW-1:0] FB_CAP   = FW'(2 * WIN_EDGES);

    logic [RW-1:0] ref_cnt;
    logic [FW-1:0] fb_cnt;
    logic [FW-1:0] fb_next;

    always_comb begin
        fb_next = fb_cnt;
        if (fb_edge && (fb_cnt != FB_CAP)) begin
            fb_next = fb_cnt + FW'(1);
        end
    end

    assign win_end  = ref_edge && (ref_cnt == REF_LAST);
    assign fb_total = fb_next;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_cnt <= '0;
            fb_cnt  <= '0;
        end else if (win_end) begin
            ref_cnt <= '0;
            fb_cnt  <= '0;
        end else begin
            if (ref_edge) begin
                ref_cnt <= ref_cnt + RW'(1);
            end
            fb_cnt <= fb_next;
        end
    end

endmodule

// File: rtl/flock_seq_divider.sv
module flock_seq_divider #(
    parameter int unsigned WIDTH = 50,
    localparam int unsigned CW = $clog2(WIDTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [WIDTH-1:0] num,
    input  logic [WIDTH-1:0] den,
    output logic             done,
    output logic [WIDTH-1:0] quo
);

    logic [WIDTH-1:0] num_sh;
    logic [WIDTH-1:0] den_r;
    logic [WIDTH-1:0] quo_r;
    logic [WIDTH:0]   rem;
    logic [WIDTH:0]   trial;
    logic [CW-1:0]    steps;
    logic             active;
    logic             fits;

    assign trial = {rem[WIDTH-1:0], num_sh[WIDTH-1]};
    assign fits  = trial >= {1'b0, den_r};
    assign quo   = quo_r;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            num_sh <= '0;
            den_r  <= '0;
            quo_r  <= '0;
            rem    <= '0;
            steps  <= '0;
            active <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                num_sh <= num;
                den_r  <= den;
                quo_r  <= '0;
                rem    <= '0;
                steps  <= CW'(WIDTH);
                active <= 1'b1;
            end else if (active) begin
                rem    <= fits ? (trial - {1'b0, den_r}) : trial;
                num_sh <= num_sh << 1;
                quo_r  <= {quo_r[WIDTH-2:0], fits};
                steps  <= steps - CW'(1);
                if (steps == CW'(1)) begin
                    active <= 1'b0;
                    done   <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/freq_lock_detect.sv
module freq_lock_detect
    import flock_pkg::*;
#(
    parameter int unsigned WIN_EDGES = 1000000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_edge,
    input  logic       fb_edge,
    input  logic [2:0] thr_code,
    output logic       locked,
    output logic [9:0] err_mag,
    output logic       err_unit_ppm,
    output logic       result_stb
);

    localparam int unsigned FW = $clog2(2 * WIN_EDGES + 1);
    localparam int unsigned DW = $clog2(WIN_EDGES + 1);
    localparam int unsigned NW = DW + SCALE_W;

    localparam logic [FW-1:0] FB_NOM   = FW'(WIN_EDGES);
    localparam logic [NW-1:0] SMALL_LIM = NW'(MAG_MAX);

    flock_state_t state, state_nx;

    logic          win_end;
    logic [FW-1:0] fb_total;
    logic [FW-1:0] diff;
    logic [NW-1:0] num_ppb;
    logic [NW-1:0] div_num;
    logic [NW-1:0] div_den;
    logic [NW-1:0] div_quo;
    logic          div_start;
    logic          div_done;

    logic [2:0]       code_q;
    logic [NW-1:0]    ppb_q;
    logic             lock_n;
    logic [MAG_W-1:0] res_mag;
    logic             res_unit;
    logic             ppb_small;

    flock_window_counter #(.WIN_EDGES(WIN_EDGES)) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_edge (ref_edge),
        .fb_edge  (fb_edge),
        .win_end  (win_end),
        .fb_total (fb_total)
    );

    // absolute count difference, never above WIN_EDGES since fb saturates at 2x
    always_comb begin
        if (fb_total >= FB_NOM) begin
            diff = fb_total - FB_NOM;
        end else begin
            diff = FB_NOM - fb_total;
        end
    end

    assign num_ppb   = NW'(diff[DW-1:0]) * NW'(PPB_SCALE);
    assign ppb_small = ppb_q <= SMALL_LIM;

    assign div_num = (state == ST_IDLE) ? num_ppb : ppb_q;
    assign div_den = (state == ST_IDLE) ? NW'(WIN_EDGES) : NW'(PPB_PER_PPM);
    assign div_start = ((state == ST_IDLE) && win_end) ||
                       ((state == ST_PPB_EVAL) && !ppb_small);

    flock_seq_divider #(.WIDTH(NW)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .start (div_start),
        .num   (div_num),
        .den   (div_den),
        .done  (div_done),
        .quo   (div_quo)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:     if (win_end) state_nx = ST_PPB_DIV;
            ST_PPB_DIV:  if (div_done) state_nx = ST_PPB_EVAL;
            ST_PPB_EVAL: state_nx = ppb_small ? ST_PUBLISH : ST_PPM_DIV;
            ST_PPM_DIV:  if (div_done) state_nx = ST_PUBLISH;
            ST_PUBLISH:  state_nx = ST_IDLE;
            default:     state_nx = ST_IDLE;
        endcase
    end

    // working registers of the measurement
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q   <= '0;
            ppb_q    <= '0;
            lock_n   <= 1'b0;
            res_mag  <= '0;
            res_unit <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (win_end) begin
                        code_q <= thr_code;
                    end
                end
                ST_PPB_DIV: begin
                    if (div_done) begin
                        ppb_q <= div_quo;
                    end
                end
                ST_PPB_EVAL: begin
                    lock_n <= ppb_q < NW'(thr_ppb(code_q));
                    if (ppb_small) begin
                        res_mag  <= ppb_q[MAG_W-1:0];
                        res_unit <= 1'b0;
                    end
                end
                ST_PPM_DIV: begin
                    if (div_done) begin
                        res_unit <= 1'b1;
                        res_mag  <= (div_quo > SMALL_LIM) ? MAG_W'(MAG_MAX)
                                                          : div_quo[MAG_W-1:0];
                    end
                end
                default: ;
            endcase
        end
    end

    // published outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked       <= 1'b0;
            err_mag      <= '0;
            err_unit_ppm <= 1'b0;
            result_stb   <= 1'b0;
        end else begin
            result_stb <= 1'b0;
            if (state == ST_PUBLISH) begin
                locked       <= lock_n;
                err_mag      <= res_mag;
                err_unit_ppm <= res_unit;
                result_stb   <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/flock_checker.sv
module flock_checker
    import flock_pkg::*;
(
    input logic         clk,
    input logic         rst_n,
    input logic         result_stb,
    input logic         locked,
    input logic [9:0]   err_mag,
    input logic         err_unit_ppm,
    input logic         win_end,
    input flock_state_t state,
    input logic         div_done
);

    // R2: one-cycle publish pulse
    p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        result_stb |=> !result_stb);

    // R2: a window never closes while a previous one is still being evaluated
    p_close_when_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        win_end |-> (state == ST_IDLE));

    // R8: published values hold between pulses
    p_hold_between_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !result_stb |-> $stable({locked, err_mag, err_unit_ppm}));

    // R5: a ppm result is never zero
    p_ppm_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (result_stb && err_unit_ppm) |-> (err_mag != 10'd0));

    // R7: at or above 300 ppm no threshold code can give lock
    p_coarse_unlock_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (result_stb && err_unit_ppm && (err_mag >= 10'd300)) |-> !locked);

    // R3: divider completions occur only while a division is awaited
    p_div_owner_r3: assert property (@(posedge clk) disable iff (!rst_n)
        div_done |-> ((state == ST_PPB_DIV) || (state == ST_PPM_DIV)));

endmodule

bind freq_lock_detect flock_checker u_flock_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .result_stb   (result_stb),
    .locked       (locked),
    .err_mag      (err_mag),
    .err_unit_ppm (err_unit_ppm),
    .win_end      (win_end),
    .state        (state),
    .div_done     (div_done)
);

// File: tb/freq_lock_detect_test.sv
`timescale 1ns/1ps
module freq_lock_detect_test;

    localparam int unsigned WIN = 4000;   // 250 ppm per count of difference
    localparam int NVEC = 10;

    typedef struct packed {
        int         d;      // feedback surplus (+) or deficit (-)
        logic [2:0] code;
        logic       lock;
        logic       unit;
        logic [9:0] mag;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{0,  3'd0, 1'b1, 1'b0, 10'd0},    // R4 R7 zero error locks even at 20 ppb
        '{1,  3'd7, 1'b1, 1'b1, 10'd250},  // R5 R6 250 ppm under 300 ppm
        '{1,  3'd6, 1'b0, 1'b1, 10'd250},  // R6 R7 over 100 ppm
        '{-1, 3'd7, 1'b1, 1'b1, 10'd250},  // R9 deficit matches surplus
        '{2,  3'd7, 1'b0, 1'b1, 10'd500},  // R7 above max threshold
        '{-4, 3'd7, 1'b0, 1'b1, 10'd1000}, // R5 R9
        '{5,  3'd7, 1'b0, 1'b1, 10'd1023}, // R5 saturation
        '{0,  3'd3, 1'b1, 1'b0, 10'd0},    // R4 back to lock
        '{-3, 3'd7, 1'b0, 1'b1, 10'd750},  // R3
        '{1,  3'd0, 1'b0, 1'b1, 10'd250}   // R6 finest code
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_edge = 1'b0;
    logic       fb_edge = 1'b0;
    logic [2:0] thr_code = 3'd0;
    logic       locked;
    logic [9:0] err_mag;
    logic       err_unit_ppm;
    logic       result_stb;

    int checks = 0;
    int errors = 0;

    logic       pend_valid = 1'b0;
    logic       pend_lock, pend_unit;
    logic [9:0] pend_mag;
    logic       last_lock = 1'b0, last_unit = 1'b0;
    logic [9:0] last_mag = 10'd0;
    logic       hold_bad;

    always #2 clk = ~clk;

    freq_lock_detect #(.WIN_EDGES(WIN)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .ref_edge     (ref_edge),
        .fb_edge      (fb_edge),
        .thr_code     (thr_code),
        .locked       (locked),
        .err_mag      (err_mag),
        .err_unit_ppm (err_unit_ppm),
        .result_stb   (result_stb)
    );

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        finish_run();
    end

    // one cycle: sample outputs at negedge, then drive new inputs
    task automatic tick(input logic r, input logic f);
        @(negedge clk);
        if (result_stb) begin
            if (!pend_valid) begin
                checks++; errors++;
                $display("FAIL R2: unexpected result pulse, actual=1 expected=0");
            end else begin
                checks++;
                if (locked !== pend_lock) begin
                    errors++;
                    $display("FAIL R7: locked actual=%0b expected=%0b", locked, pend_lock);
                end
                checks++;
                if (err_unit_ppm !== pend_unit) begin
                    errors++;
                    $display("FAIL R4: unit actual=%0b expected=%0b", err_unit_ppm, pend_unit);
                end
                checks++;
                if (err_mag !== pend_mag) begin
                    errors++;
                    if (pend_unit)
                        $display("FAIL R5: mag actual=%0d expected=%0d", err_mag, pend_mag);
                    else
                        $display("FAIL R3: mag actual=%0d expected=%0d", err_mag, pend_mag);
                end
                pend_valid = 1'b0;
            end
            last_lock = locked;
            last_unit = err_unit_ppm;
            last_mag  = err_mag;
        end else if (rst_n && ({locked, err_unit_ppm, err_mag} !== {last_lock, last_unit, last_mag})) begin
            hold_bad = 1'b1;
        end
        ref_edge = r;
        fb_edge  = f;
    endtask

    // one window of WIN reference edges, with d extra or missing feedback edges
    task automatic run_window(input vec_t v);
        thr_code = v.code;
        hold_bad = 1'b0;
        for (int i = 0; i < int'(WIN); i++) begin
            tick(1'b1, !(v.d < 0 && i < -v.d));
            tick(1'b0, (v.d > 0 && i < v.d));
        end
        checks++;
        if (hold_bad) begin
            errors++;
            $display("FAIL R8: outputs changed without pulse, actual=changed expected=held");
        end
        checks++;
        if (pend_valid) begin
            errors++;
            $display("FAIL R2: previous window result missing, actual=0 expected=1");
        end
        pend_valid = 1'b1;
        pend_lock  = v.lock;
        pend_unit  = v.unit;
        pend_mag   = v.mag;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs idle during reset
        checks++;
        if ({locked, err_unit_ppm, err_mag, result_stb} !== 13'd0) begin
            errors++;
            $display("FAIL R1: reset outputs actual=%0h expected=0",
                     {locked, err_unit_ppm, err_mag, result_stb});
        end
        rst_n = 1'b1;

        for (int k = 0; k < NVEC; k++) begin
            run_window(VECS[k]);
        end

        // R3: feedback at twice the reference saturates to full scale
        run_window('{int'(WIN), 3'd7, 1'b0, 1'b1, 10'd1023});
        // R9 R3: no feedback at all gives the same full-scale error
        run_window('{-int'(WIN), 3'd7, 1'b0, 1'b1, 10'd1023});
        // flush window carries out the last pending result
        run_window('{0, 3'd0, 1'b1, 1'b0, 10'd0});

        // R1: reset in operation clears the published results
        @(negedge clk);
        rst_n = 1'b0;
        ref_edge = 1'b0;
        fb_edge = 1'b0;
        @(negedge clk);
        @(negedge clk);
        checks++;
        if ({locked, err_unit_ppm, err_mag, result_stb} !== 13'd0) begin
            errors++;
            $display("FAIL R1: outputs after reset actual=%0h expected=0",
                     {locked, err_unit_ppm, err_mag, result_stb});
        end
        finish_run();
    end

endmodule